// File: doc/BRIEF.md
# USB Endpoint Bank Buffer Controller

This block holds the packet storage of a single USB device endpoint. The storage is split into one or two equal banks. A packet engine sits on the bus side and a CPU sits on the register side. When the endpoint receives data (OUT direction), the packet engine streams each received packet into a free bank, and the CPU drains the bank and then releases it. When the endpoint sends data (IN direction), the CPU fills a free bank and commits it. The packet engine then reads that bank by address when the host asks for data, and frees the bank once the host has taken it.

A two-bit busy-bank count tracks how many banks hold data. Four sticky status flags, each with an interrupt enable, report these events:

- a packet was received;
- an oversize packet was truncated;
- a request or packet found no usable bank;
- a packet arrived with a bad checksum.

A kill command lets the CPU withdraw committed IN data one bank at a time, always starting with the newest bank. Software repeats the kill until the busy count reaches zero and then pulses the endpoint reset.

Top module: `ep_bank_ctrl`

## Requirements
- R1: Asserting `ep_rst` for one cycle leaves, from the next cycle on, `busy_banks`=0, `flag_q`=0, `cpu_kill_busy`=0 and both bank pointers at bank 0. The global reset `rst_n` does the same.
- R2: In OUT direction (`cfg_dir_in`=0), an OUT packet that starts while a bank is free is stored. One cycle after `pe_out_end`, `pe_out_ack` pulses, `busy_banks` is one higher and flag bit 0 (received) is set. The CPU then reads the stored bytes in arrival order on `cpu_rd_byte`, advancing one byte per `cpu_rd_vld`, and `cpu_rd_len` gives the stored byte count.
- R3: An OUT packet that starts while every bank is busy is discarded. One cycle after its end, `pe_out_drop` pulses instead of `pe_out_ack`, flag bit 2 (underflow) is set, and both `busy_banks` and the contents of the stored banks stay unchanged.
- R4: An OUT packet longer than `BANK_BYTES` keeps only its first `BANK_BYTES` bytes, and `cpu_rd_len` reads `BANK_BYTES`. The packet sets flag bit 1 (overflow), is still acknowledged, and still sets flag bit 0.
- R5: An OUT packet whose end carries `pe_out_crc_bad`=1 is stored as normal. It sets flag bit 3 (CRC error) together with flag bit 0.
- R6: In IN direction (`cfg_dir_in`=1), a `pe_in_req` while `busy_banks`=0 sets flag bit 2 (underflow) one cycle later.
- R7: In IN direction, the CPU writes bytes with `cpu_wr_vld` and then pulses `cpu_commit`. From the next cycle, `busy_banks` is one higher, `pe_in_avail`=1, `pe_in_len` equals the number of bytes written, and `pe_in_byte` returns byte `pe_in_addr` of that bank. A `pe_in_done` lowers `busy_banks` by one.
- R8: Banks are used in ping-pong order. The bank offered to the reader (`pe_in_len`/`pe_in_byte`, or `cpu_rd_len`/`cpu_rd_byte`) is always the oldest filled bank.
- R9: In IN direction, `cpu_kill_req` makes `cpu_kill_busy` read 1 in the next cycle. `cpu_kill_busy` returns to 0 one cycle later, unless a commit or send falls in that cycle, in which case the kill waits. At that point the most recently committed bank is discarded and `busy_banks` drops by one. If no bank is busy, the kill only clears `cpu_kill_busy`.
- R10: Each flag stays set until the CPU writes 1 to its bit of `flag_clr`. Bits of `flag_clr` that are 0, or that point at a clear flag, change nothing. `irq` is 1 exactly when some flag and its `irq_en` bit are both 1.
- R11: `busy_banks` never exceeds `NUM_BANKS`. A commit or CPU write while every bank is busy is ignored.
- R12: In OUT direction, `cpu_release` lowers `busy_banks` by one. `cpu_bank_ok` is 1 when at least one bank is busy in OUT direction, and when at least one bank is free in IN direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_rst | input | 1 | Synchronous endpoint reset |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| pe_out_start | input | 1 | OUT packet begins |
| pe_out_vld | input | 1 | OUT data byte valid |
| pe_out_byte | input | DATA_W | OUT data byte |
| pe_out_end | input | 1 | OUT packet ends |
| pe_out_crc_bad | input | 1 | Checksum failed, qualified by pe_out_end |
| pe_out_ack | output | 1 | Packet stored, acknowledge it |
| pe_out_drop | output | 1 | Packet discarded |
| pe_in_req | input | 1 | Host asks for IN data |
| pe_in_addr | input | AW | Byte address within the bank being sent |
| pe_in_byte | output | DATA_W | Byte at pe_in_addr |
| pe_in_len | output | LW | Byte count of the bank being sent |
| pe_in_avail | output | 1 | An IN bank is ready |
| pe_in_done | input | 1 | Host took the bank, free it |
| cpu_wr_vld | input | 1 | CPU writes one IN byte |
| cpu_wr_byte | input | DATA_W | CPU write data |
| cpu_commit | input | 1 | CPU hands the filled IN bank over |
| cpu_rd_vld | input | 1 | CPU consumes one OUT byte |
| cpu_rd_byte | output | DATA_W | Current OUT byte |
| cpu_rd_len | output | LW | Byte count of the current OUT bank |
| cpu_release | input | 1 | CPU frees the current OUT bank |
| cpu_bank_ok | output | 1 | CPU may access a bank |
| cpu_kill_req | input | 1 | Discard the newest IN bank |
| cpu_kill_busy | output | 1 | Kill in progress |
| busy_banks | output | 2 | Number of banks holding data |
| flag_q | output | 4 | Sticky flags: 0 received, 1 overflow, 2 underflow, 3 CRC error |
| flag_clr | input | 4 | Write-1-to-clear for flag_q |
| irq_en | input | 4 | Interrupt enables |
| irq | output | 1 | Interrupt request |

## Verification
The registered results appear one cycle after the input that causes them:

- `pe_out_ack` and `pe_out_drop`, together with the flags and `busy_banks` for an OUT packet, follow the cycle of `pe_out_end`.
- The IN flags and count follow `pe_in_req`, `pe_in_done` or `cpu_commit`.
- `cpu_kill_busy` rises one cycle after `cpu_kill_req`, and the count drops one cycle after that.

The read data ports and `irq` are combinational from registered state and from `pe_in_addr`/`irq_en`, so they are valid in the same cycle. The bench drives every input on the falling edge and samples at the next falling edge. That sample point falls half a period after the rising edge that registers the result, so each check lands exactly in the cycle the result is due.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;

  localparam int FLAG_N = 4;
  localparam int F_RX   = 0;
  localparam int F_OVF  = 1;
  localparam int F_UNF  = 2;
  localparam int F_CRC  = 3;

  // next bank in ping-pong order; single-bank endpoints stay on bank 0
  function automatic logic bank_step(input logic p, input int nb);
    return (nb == 2) ? ~p : 1'b0;
  endfunction

  // busy-count arithmetic: one possible increment and one possible decrement
  function automatic logic [1:0] count_next(input logic [1:0] c,
                                            input logic inc, input logic dec);
    return c + {1'b0, inc} - {1'b0, dec};
  endfunction

  // byte index advance that stops at the bank size
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v < lim) ? v + 1 : lim;
  endfunction

endpackage

// File: rtl/ep_bank_store.sv
module ep_bank_store #(
  parameter int NB = 2,
  parameter int BB = 8,
  parameter int AW = 3,
  parameter int LW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic          wbank,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          lwe,
  input  logic          lbank,
  input  logic [LW-1:0] lval,
  input  logic          abank,
  input  logic [AW-1:0] aaddr,
  output logic [DW-1:0] adata,
  input  logic          bbank,
  input  logic [AW-1:0] baddr,
  output logic [DW-1:0] bdata,
  input  logic          len_bank,
  output logic [LW-1:0] len_val
);
  localparam int DEPTH = NB * BB;
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem   [DEPTH];
  logic [LW-1:0] len_q [NB];

  function automatic logic [IW-1:0] flat(input logic bank, input logic [AW-1:0] a);
    int bi;
    bi = (NB == 1) ? 0 : int'(bank);
    return IW'(bi * BB + int'(a));
  endfunction

  function automatic int bsel(input logic bank);
    return (NB == 1) ? 0 : int'(bank);
  endfunction

  always_ff @(posedge clk) begin
    if (we) mem[flat(wbank, waddr)] <= wdata;
  end

  for (genvar g = 0; g < NB; g++) begin : g_len
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               len_q[g] <= '0;
      else if (clr)                             len_q[g] <= '0;
      else if (lwe && (bsel(lbank) == g))       len_q[g] <= lval;
    end
  end

  assign adata   = mem[flat(abank, aaddr)];
  assign bdata   = mem[flat(bbank, baddr)];
  assign len_val = len_q[bsel(len_bank)];

endmodule

// File: rtl/ep_bank_track.sv
module ep_bank_track #(
  parameter int NB = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       adv_wr,
  input  logic       adv_rd,
  input  logic       back_wr,
  output logic       wp,
  output logic       rp,
  output logic [1:0] cnt,
  output logic       full,
  output logic       empty
);
  import ep_bank_pkg::*;

  localparam logic [1:0] NB_C = 2'(NB);

  logic [1:0] cnt_q;

  if (NB == 2) begin : g_dual
    logic wp_q, rp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               wp_q <= 1'b0;
      else if (clr)             wp_q <= 1'b0;
      else if (adv_wr | back_wr) wp_q <= bank_step(wp_q, NB);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rp_q <= 1'b0;
      else if (clr)    rp_q <= 1'b0;
      else if (adv_rd) rp_q <= bank_step(rp_q, NB);
    end
    assign wp = wp_q;
    assign rp = rp_q;
  end else begin : g_single
    assign wp = 1'b0;
    assign rp = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= count_next(cnt_q, adv_wr, adv_rd | back_wr);
  end

  assign cnt   = cnt_q;
  assign full  = (cnt_q == NB_C);
  assign empty = (cnt_q == 2'd0);

  // R11
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= NB_C);

  // R11
  no_fill_full_chk: assert property (@(posedge clk) disable iff (!rst_n) adv_wr |-> !full);

  // R12
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_rd | back_wr) |-> !empty);

  // R9
  kill_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (back_wr && !clr && !adv_wr && !adv_rd) |=> cnt_q == $past(cnt_q) - 2'd1);

endmodule

// File: rtl/ep_status_flags.sv
module ep_status_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_all,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flag_q,
  output logic         irq
);
  logic [N-1:0] f_q;

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         f_q <= '0;
    else if (clear_all) f_q <= '0;
    else                f_q <= (f_q & ~clr_i) | set_i;
  end

  assign flag_q = f_q;
  assign irq    = |(f_q & en_i);

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|set_i) && !clear_all) |=> ((f_q & $past(set_i)) == $past(set_i)));

  // R10
  flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(clr_i & ~set_i & f_q)) && !clear_all) |=> ((f_q & $past(clr_i & ~set_i)) == '0));

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i == '0) && (clr_i == '0) && !clear_all) |=> $stable(f_q));

endmodule

// File: rtl/ep_bank_ctrl.sv
module ep_bank_ctrl #(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 8,
  parameter int DATA_W     = 8,
  localparam int AW        = $clog2(BANK_BYTES),
  localparam int LW        = $clog2(BANK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ep_rst,
  input  logic              cfg_dir_in,
  input  logic              pe_out_start,
  input  logic              pe_out_vld,
  input  logic [DATA_W-1:0] pe_out_byte,
  input  logic              pe_out_end,
  input  logic              pe_out_crc_bad,
  output logic              pe_out_ack,
  output logic              pe_out_drop,
  input  logic              pe_in_req,
  input  logic [AW-1:0]     pe_in_addr,
  output logic [DATA_W-1:0] pe_in_byte,
  output logic [LW-1:0]     pe_in_len,
  output logic              pe_in_avail,
  input  logic              pe_in_done,
  input  logic              cpu_wr_vld,
  input  logic [DATA_W-1:0] cpu_wr_byte,
  input  logic              cpu_commit,
  input  logic              cpu_rd_vld,
  output logic [DATA_W-1:0] cpu_rd_byte,
  output logic [LW-1:0]     cpu_rd_len,
  input  logic              cpu_release,
  output logic              cpu_bank_ok,
  input  logic              cpu_kill_req,
  output logic              cpu_kill_busy,
  output logic [1:0]        busy_banks,
  output logic [3:0]        flag_q,
  input  logic [3:0]        flag_clr,
  input  logic [3:0]        irq_en,
  output logic              irq
);
  import ep_bank_pkg::*;

  localparam logic [LW-1:0] BB_C = LW'(BANK_BYTES);

  // bank tracker view
  logic       wp, rp, full, empty;
  logic [1:0] cnt;

  // sequencing state
  logic          in_pkt, pkt_drop, pkt_ovf;
  logic [LW-1:0] wr_idx, rd_idx;
  logic          kill_q, ack_q, drop_q;
  logic [LW-1:0] cur_len;

  // named internal events
  logic ev_out_begin, ev_out_byte, ev_out_close, ev_store, ev_drop, ev_trunc;
  logic ev_release, ev_cpu_rd, ev_cpu_wr, ev_commit, ev_send, ev_starve;
  logic ev_kill_go, ev_kill_pop, mem_we;
  logic [FLAG_N-1:0] flag_set;

  assign ev_out_begin = ~cfg_dir_in & pe_out_start;
  assign ev_out_byte  = ~cfg_dir_in & in_pkt & ~pkt_drop & pe_out_vld;
  assign ev_out_close = ~cfg_dir_in & in_pkt & pe_out_end;
  assign ev_store     = ev_out_close & ~pkt_drop;
  assign ev_drop      = ev_out_close & pkt_drop;
  assign ev_trunc     = ev_out_byte & (wr_idx == BB_C);
  assign ev_release   = ~cfg_dir_in & cpu_release & ~empty;
  assign ev_cpu_rd    = ~cfg_dir_in & cpu_rd_vld & ~empty & (rd_idx < cur_len);
  assign ev_cpu_wr    = cfg_dir_in & cpu_wr_vld & ~full & (wr_idx < BB_C);
  assign ev_commit    = cfg_dir_in & cpu_commit & ~full;
  assign ev_send      = cfg_dir_in & pe_in_done & ~empty;
  assign ev_starve    = cfg_dir_in & pe_in_req & empty;
  assign ev_kill_go   = kill_q & ~ev_commit & ~ev_send;
  assign ev_kill_pop  = ev_kill_go & ~empty;
  assign mem_we       = (ev_out_byte & (wr_idx < BB_C)) | ev_cpu_wr;

  ep_bank_track #(.NB(NUM_BANKS)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ep_rst),
    .adv_wr  (ev_store | ev_commit),
    .adv_rd  (ev_release | ev_send),
    .back_wr (ev_kill_pop),
    .wp      (wp),
    .rp      (rp),
    .cnt     (cnt),
    .full    (full),
    .empty   (empty)
  );

  ep_bank_store #(
    .NB(NUM_BANKS), .BB(BANK_BYTES), .AW(AW), .LW(LW), .DW(DATA_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ep_rst),
    .we       (mem_we),
    .wbank    (wp),
    .waddr    (wr_idx[AW-1:0]),
    .wdata    (cfg_dir_in ? cpu_wr_byte : pe_out_byte),
    .lwe      (ev_store | ev_commit),
    .lbank    (wp),
    .lval     (wr_idx),
    .abank    (rp),
    .aaddr    (pe_in_addr),
    .adata    (pe_in_byte),
    .bbank    (rp),
    .baddr    (rd_idx[AW-1:0]),
    .bdata    (cpu_rd_byte),
    .len_bank (rp),
    .len_val  (cur_len)
  );

  always_comb begin
    flag_set        = '0;
    flag_set[F_RX]  = ev_store;
    flag_set[F_OVF] = ev_store & pkt_ovf;
    flag_set[F_UNF] = ev_drop | ev_starve;
    flag_set[F_CRC] = ev_store & pe_out_crc_bad;
  end

  ep_status_flags #(.N(FLAG_N)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (ep_rst),
    .set_i     (flag_set),
    .clr_i     (flag_clr),
    .en_i      (irq_en),
    .flag_q    (flag_q),
    .irq       (irq)
  );

  // OUT packet framing: the drop decision is taken once, at the start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt   <= 1'b0;
      pkt_drop <= 1'b0;
      pkt_ovf  <= 1'b0;
    end else if (ep_rst) begin
      in_pkt   <= 1'b0;
      pkt_drop <= 1'b0;
      pkt_ovf  <= 1'b0;
    end else if (ev_out_begin) begin
      in_pkt   <= 1'b1;
      pkt_drop <= full;
      pkt_ovf  <= 1'b0;
    end else begin
      if (ev_out_close) in_pkt  <= 1'b0;
      if (ev_trunc)     pkt_ovf <= 1'b1;
    end
  end

  // shared write index: OUT receive or CPU IN fill (direction is static)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           wr_idx <= '0;
    else if (ep_rst || ev_out_begin)      wr_idx <= '0;
    else if (ev_commit || ev_kill_go)     wr_idx <= '0;
    else if (ev_out_byte || ev_cpu_wr)
      wr_idx <= LW'(sat_inc(int'(wr_idx), BANK_BYTES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rd_idx <= '0;
    else if (ep_rst || ev_release)  rd_idx <= '0;
    else if (ev_cpu_rd)             rd_idx <= rd_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    kill_q <= 1'b0;
    else if (ep_rst)               kill_q <= 1'b0;
    else if (ev_kill_go)           kill_q <= 1'b0;
    else if (cfg_dir_in && cpu_kill_req) kill_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      ack_q  <= ev_store & ~ep_rst;
      drop_q <= ev_drop & ~ep_rst;
    end
  end

  assign pe_out_ack    = ack_q;
  assign pe_out_drop   = drop_q;
  assign pe_in_len     = cur_len;
  assign pe_in_avail   = cfg_dir_in & ~empty;
  assign cpu_rd_len    = cur_len;
  assign cpu_bank_ok   = cfg_dir_in ? ~full : ~empty;
  assign cpu_kill_busy = kill_q;
  assign busy_banks    = cnt;

  // R2
  ack_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pe_out_ack, pe_out_drop}));

  // R3
  drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drop && !ep_rst && !ev_release) |=> busy_banks == $past(busy_banks));

  // R4
  store_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store |-> wr_idx <= BB_C);

  // R9
  kill_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kill_q) |-> $past(cpu_kill_req && cfg_dir_in));

endmodule

// File: tb/sim_ep_bank_ctrl.sv
module sim_ep_bank_ctrl;
  localparam int BB = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ep_rst, cfg_dir_in;
  logic pe_out_start, pe_out_vld, pe_out_end, pe_out_crc_bad, pe_out_ack, pe_out_drop;
  logic [7:0] pe_out_byte, pe_in_byte, cpu_wr_byte, cpu_rd_byte;
  logic pe_in_req, pe_in_avail, pe_in_done;
  logic [2:0] pe_in_addr;
  logic [3:0] pe_in_len, cpu_rd_len;
  logic cpu_wr_vld, cpu_commit, cpu_rd_vld, cpu_release, cpu_bank_ok;
  logic cpu_kill_req, cpu_kill_busy, irq;
  logic [1:0] busy_banks;
  logic [3:0] flag_q, flag_clr, irq_en;

  ep_bank_ctrl #(.NUM_BANKS(2), .BANK_BYTES(BB), .DATA_W(8)) u0 (.*);

  int tests = 0, fails = 0;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // OUT packet: {length, crc_bad, first byte}
  localparam logic [23:0] OUT_VEC [6] = '{
    {8'd3,  8'd0, 8'h10},
    {8'd8,  8'd0, 8'h20},
    {8'd11, 8'd0, 8'h30},
    {8'd5,  8'd1, 8'h40},
    {8'd1,  8'd0, 8'h55},
    {8'd0,  8'd0, 8'h00}
  };

  logic got_ack, got_drop;

  task automatic send_out(input int n, input logic crc, input logic [7:0] base);
    pe_out_start = 1'b1;
    @(negedge clk);
    pe_out_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      pe_out_vld = 1'b1;
      pe_out_byte = base + 8'(i);
      @(negedge clk);
    end
    pe_out_vld = 1'b0;
    pe_out_end = 1'b1;
    pe_out_crc_bad = crc;
    @(negedge clk);
    got_ack = pe_out_ack;
    got_drop = pe_out_drop;
    pe_out_end = 1'b0;
    pe_out_crc_bad = 1'b0;
  endtask

  task automatic read_out(input int n, input logic [7:0] base, input string req);
    for (int i = 0; i < n; i++) begin
      check(req, cpu_rd_byte, int'(base + 8'(i)));
      cpu_rd_vld = 1'b1;
      @(negedge clk);
      cpu_rd_vld = 1'b0;
    end
    cpu_release = 1'b1;
    @(negedge clk);
    cpu_release = 1'b0;
  endtask

  task automatic clear_flags(input logic [3:0] m);
    flag_clr = m;
    @(negedge clk);
    flag_clr = '0;
  endtask

  task automatic cpu_fill(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      cpu_wr_vld = 1'b1;
      cpu_wr_byte = base + 8'(i);
      @(negedge clk);
    end
    cpu_wr_vld = 1'b0;
    cpu_commit = 1'b1;
    @(negedge clk);
    cpu_commit = 1'b0;
  endtask

  task automatic pulse_done();
    pe_in_done = 1'b1;
    @(negedge clk);
    pe_in_done = 1'b0;
  endtask

  task automatic kill_once(input int exp_after);
    cpu_kill_req = 1'b1;
    @(negedge clk);
    cpu_kill_req = 1'b0;
    check("R9 kill busy", cpu_kill_busy, 1);
    @(negedge clk);
    check("R9 kill done", cpu_kill_busy, 0);
    check("R9 count", busy_banks, exp_after);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; ep_rst = 0; cfg_dir_in = 0;
    pe_out_start = 0; pe_out_vld = 0; pe_out_byte = 0; pe_out_end = 0; pe_out_crc_bad = 0;
    pe_in_req = 0; pe_in_addr = 0; pe_in_done = 0;
    cpu_wr_vld = 0; cpu_wr_byte = 0; cpu_commit = 0; cpu_rd_vld = 0; cpu_release = 0;
    cpu_kill_req = 0; flag_clr = 0; irq_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset count", busy_banks, 0);
    check("R1 reset flags", flag_q, 0);
    check("R1 reset kill", cpu_kill_busy, 0);
    check("R12 reset bank_ok", cpu_bank_ok, 0);

    // table walk: OUT packets R2 R4 R5
    foreach (OUT_VEC[k]) begin
      int n, stored, expf;
      logic crc;
      logic [7:0] base;
      n = int'(OUT_VEC[k][23:16]);
      crc = OUT_VEC[k][8];
      base = OUT_VEC[k][7:0];
      stored = (n > BB) ? BB : n;
      expf = 1 | ((n > BB) ? 2 : 0) | (crc ? 8 : 0);
      send_out(n, crc, base);
      check("R2 ack", got_ack, 1);
      check("R2 no drop", got_drop, 0);
      check("R2 count", busy_banks, 1);
      check("R4 R5 flags", flag_q, expf);
      check("R4 stored length", cpu_rd_len, stored);
      read_out(stored, base, "R2 data");
      check("R12 release", busy_banks, 0);
      clear_flags(4'hF);
      check("R10 clear", flag_q, 0);
    end

    // R3 and R8: fill both banks, third packet is dropped
    send_out(2, 1'b0, 8'hA0);
    send_out(3, 1'b0, 8'hB0);
    check("R11 two busy", busy_banks, 2);
    check("R12 bank_ok out", cpu_bank_ok, 1);
    clear_flags(4'hF);
    send_out(4, 1'b0, 8'hC0);
    check("R3 drop", got_drop, 1);
    check("R3 no ack", got_ack, 0);
    check("R3 count kept", busy_banks, 2);
    check("R3 underflow", flag_q, 4);
    check("R8 oldest first", cpu_rd_len, 2);
    read_out(2, 8'hA0, "R3 R8 bank0 intact");
    check("R8 second", cpu_rd_len, 3);
    read_out(3, 8'hB0, "R3 R8 bank1 intact");
    check("R12 empty", cpu_bank_ok, 0);

    // R10 interrupts and selective clear
    check("R10 irq masked", irq, 0);
    irq_en = 4'b0100;
    @(negedge clk);
    check("R10 irq on", irq, 1);
    clear_flags(4'b0001);
    check("R10 other bit", flag_q, 4);
    clear_flags(4'b0100);
    check("R10 cleared", flag_q, 0);
    check("R10 irq off", irq, 0);
    irq_en = 0;

    // R1 endpoint reset
    send_out(2, 1'b1, 8'h11);
    check("R5 crc+rx", flag_q, 9);
    ep_rst = 1;
    @(negedge clk);
    ep_rst = 0;
    check("R1 ep count", busy_banks, 0);
    check("R1 ep flags", flag_q, 0);

    // IN direction
    cfg_dir_in = 1;
    @(negedge clk);
    check("R12 in bank_ok", cpu_bank_ok, 1);
    check("R7 not avail", pe_in_avail, 0);
    pe_in_req = 1;
    @(negedge clk);
    pe_in_req = 0;
    check("R6 underflow", flag_q, 4);
    clear_flags(4'hF);

    cpu_fill(4, 8'h60);
    check("R7 count", busy_banks, 1);
    check("R7 avail", pe_in_avail, 1);
    check("R7 len", pe_in_len, 4);
    for (int i = 0; i < 4; i++) begin
      pe_in_addr = 3'(i);
      #1;
      check("R7 in data", pe_in_byte, 8'h60 + i);
    end
    cpu_fill(2, 8'h70);
    check("R11 full", busy_banks, 2);
    check("R12 in full", cpu_bank_ok, 0);
    cpu_fill(1, 8'hEE);
    check("R11 commit ignored", busy_banks, 2);
    check("R8 first bank", pe_in_len, 4);
    pulse_done();
    check("R7 done", busy_banks, 1);
    check("R8 next len", pe_in_len, 2);
    pe_in_addr = 0;
    #1;
    check("R8 next data", pe_in_byte, 8'h70);

    kill_once(0);
    check("R9 none avail", pe_in_avail, 0);

    cpu_fill(3, 8'h80);
    cpu_fill(5, 8'h90);
    kill_once(1);
    check("R9 older kept", pe_in_len, 3);
    cpu_fill(6, 8'hA0);
    check("R9 refill", busy_banks, 2);
    pulse_done();
    check("R9 refill len", pe_in_len, 6);
    pe_in_addr = 0;
    #1;
    check("R9 refill data", pe_in_byte, 8'hA0);
    kill_once(0);
    kill_once(0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule